// File: doc/BRIEF.md
# Register Unlock Sequence Detector

This block guards an extended register set behind two conditions. The first is a key. The CPU writes bytes to a dedicated key port, and a matcher compares each one with the next byte of a fixed 17-byte key. The extended features unlock only after every key byte has arrived in the right order. Once the block unlocks, it stays unlocked until reset.

The second condition is a mapping command on the gate-array port. One command value maps the extended register window into the CPU memory space, and another value removes it. The block tracks this map state whether or not the key has been accepted. It drives a single window-enable output, which is high only while the block is unlocked and the window is mapped.

The CPU side is a plain write strobe with an 8-bit upper port address and an 8-bit data byte, sampled on the rising clock edge. All outputs are registered and change on the clock edge that takes the write.

Top module: `unlock_gate`

## Requirements
- R1: After reset, `unlocked` and `window_en` are 0, the matcher waits for the first key byte, and the window is unmapped.
- R2: A key write is `wr_en`=1 with `wr_port`=0xBC. After 17 consecutive key writes carrying FF 00 FF 77 B3 51 A8 D4 62 39 9C 46 2B 15 8A CD EE in that order, `unlocked` is 1 in the cycle after the write of the final byte (EE), and not earlier.
- R3: A key write whose byte differs from the expected key byte sends the matcher back to the start. If that byte is FF, it counts as the first key byte, so the next expected byte is 00.
- R4: Writes to any port other than 0xBC, and any cycle with `wr_en`=0, leave the matcher position and `unlocked` unchanged.
- R5: Once `unlocked` is 1, it stays 1 until reset. Later key writes of any value have no effect on it.
- R6: A write of 0xB8 to port 0x7F maps the window and a write of 0xA8 to port 0x7F unmaps it. Any other byte on port 0x7F, and either command byte written to any other port, leaves the map state unchanged. The map state is tracked while the block is still locked.
- R7: `window_en` is 1 exactly when `unlocked` is 1 and the window is mapped. It reflects a change of either in the cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_port | input | 8 | Upper port address byte of the write |
| wr_data | input | 8 | Data byte of the write |
| unlocked | output | 1 | Key has been accepted (sticky until reset) |
| window_en | output | 1 | Extended register window is mapped and usable |

## Verification
The bench builds the block with its default parameters: key port 0xBC, gate-array port 0x7F, commands 0xB8 and 0xA8, and the 17-byte key. With this configuration, every one of the 255 wrong byte values can be swept at the first position, at a middle position and at the final key position, each from a fresh reset. The sweep shows that only FF resumes the key at position 1, and that every other value restarts it. It also shows that a wrong final byte never unlocks the block. The remaining positions are tested with a small set of wrong values. Directed sequences then cover the following cases:
- foreign-port writes and idle strobes interleaved with the key
- stickiness of `unlocked` after it is set
- mapping the window before unlocking
- command bytes written to the wrong port
- non-command bytes written to the gate-array port

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef logic [7:0] byte_t;

  localparam int KEY_LEN = 17;
  localparam int POS_W   = $clog2(KEY_LEN);

  // Expected key byte at a given position of the ordered key.
  function automatic byte_t key_byte(input int idx);
    byte_t b;
    case (idx)
      0:  b = 8'hFF;
      1:  b = 8'h00;
      2:  b = 8'hFF;
      3:  b = 8'h77;
      4:  b = 8'hB3;
      5:  b = 8'h51;
      6:  b = 8'hA8;
      7:  b = 8'hD4;
      8:  b = 8'h62;
      9:  b = 8'h39;
      10: b = 8'h9C;
      11: b = 8'h46;
      12: b = 8'h2B;
      13: b = 8'h15;
      14: b = 8'h8A;
      15: b = 8'hCD;
      16: b = 8'hEE;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // Position the matcher falls back to after a mismatching byte.
  function automatic int restart_pos(input byte_t data);
    return (data == key_byte(0)) ? 1 : 0;
  endfunction

endpackage

// File: rtl/unlock_port_decode.sv
module unlock_port_decode #(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] KEY_PORT = 8'hBC,
  parameter logic [PORT_W-1:0] GA_PORT  = 8'h7F,
  parameter logic [7:0] CMD_MAP   = 8'hB8,
  parameter logic [7:0] CMD_UNMAP = 8'hA8
) (
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [7:0]        wr_data,
  output logic              key_wr,
  output logic              map_cmd,
  output logic              unmap_cmd
);

  logic ga_wr;

  always_comb begin
    key_wr    = wr_en && (wr_port == KEY_PORT);
    ga_wr     = wr_en && (wr_port == GA_PORT);
    map_cmd   = ga_wr && (wr_data == CMD_MAP);
    unmap_cmd = ga_wr && (wr_data == CMD_UNMAP);
  end

endmodule

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher
  import unlock_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  key_wr,
  input  byte_t wr_data,
  output logic  unlocked
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(KEY_LEN - 1);

  logic [POS_W-1:0] pos;
  logic             key_hit;
  logic             key_last;
  logic             key_done;
  logic [POS_W-1:0] miss_pos;

  always_comb begin
    key_hit  = (wr_data == key_byte(int'(pos)));
    key_last = (pos == LAST_POS);
    key_done = key_wr && !unlocked && key_hit && key_last;
    miss_pos = POS_W'(restart_pos(wr_data));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      unlocked <= 1'b0;
    end else if (key_wr && !unlocked) begin
      if (key_done) begin
        pos      <= '0;
        unlocked <= 1'b1;
      end else if (key_hit) begin
        pos <= pos + 1'b1;
      end else begin
        pos <= miss_pos;
      end
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST_POS);

  assert_unlock_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_last && key_hit));

  assert_restart_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && !key_hit && wr_data == 8'hFF) |=> pos == POS_W'(1));

  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !unlocked && !key_hit && wr_data != 8'hFF) |=> pos == '0);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(pos) && $stable(unlocked));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

endmodule

// File: rtl/unlock_page_ctrl.sv
module unlock_page_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic map_cmd,
  input  logic unmap_cmd,
  output logic mapped
);

  always_ff @(posedge clk) begin
    if (!rst_n)         mapped <= 1'b0;
    else if (map_cmd)   mapped <= 1'b1;
    else if (unmap_cmd) mapped <= 1'b0;
  end

  assert_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
    map_cmd |=> mapped);

  assert_unmap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unmap_cmd |=> !mapped);

  assert_map_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_cmd && !unmap_cmd) |=> $stable(mapped));

  assert_cmd_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_cmd && unmap_cmd));

endmodule

// File: rtl/unlock_gate.sv
module unlock_gate #(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] KEY_PORT = 8'hBC,
  parameter logic [PORT_W-1:0] GA_PORT  = 8'h7F,
  parameter logic [7:0] CMD_MAP   = 8'hB8,
  parameter logic [7:0] CMD_UNMAP = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [7:0]        wr_data,
  output logic              unlocked,
  output logic              window_en
);

  logic key_wr;
  logic map_cmd;
  logic unmap_cmd;
  logic mapped;

  unlock_port_decode #(
    .PORT_W   (PORT_W),
    .KEY_PORT (KEY_PORT),
    .GA_PORT  (GA_PORT),
    .CMD_MAP  (CMD_MAP),
    .CMD_UNMAP(CMD_UNMAP)
  ) u_decode (
    .wr_en    (wr_en),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .key_wr   (key_wr),
    .map_cmd  (map_cmd),
    .unmap_cmd(unmap_cmd)
  );

  unlock_key_matcher u_matcher (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .wr_data (wr_data),
    .unlocked(unlocked)
  );

  unlock_page_ctrl u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .map_cmd  (map_cmd),
    .unmap_cmd(unmap_cmd),
    .mapped   (mapped)
  );

  assign window_en = unlocked && mapped;

  assert_window_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_en) |-> ($past(map_cmd) || $past(key_wr)));

  assert_window_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_en) |-> $past(unmap_cmd));

endmodule

// File: tb/unlock_gate_test.sv
module unlock_gate_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;

  localparam logic [7:0] KEYB [17] = '{8'hFF, 8'h00, 8'hFF, 8'h77, 8'hB3, 8'h51,
    8'hA8, 8'hD4, 8'h62, 8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_port = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       unlocked;
  logic       window_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  unlock_gate uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .unlocked (unlocked),
    .window_en(window_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b, expected %b", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] port, input logic [7:0] data);
    wr_en = 1'b1;
    wr_port = port;
    wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i <= upto; i++) wr(8'hBC, KEYB[i]);
  endtask

  task automatic sweep_pos(input int k, input logic [7:0] v);
    logic exp;
    if (v == KEYB[k]) return;
    do_reset();
    if (k > 0) send_key(0, k - 1);
    wr(8'hBC, v);
    chk("R3 no unlock on wrong byte", unlocked, 1'b0);
    send_key(1, 16);
    exp = (v == 8'hFF);
    chk($sformatf("R3 restart pos=%0d val=%02h", k, v), unlocked, exp);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 unlocked after reset", unlocked, 1'b0);
    chk("R1 window after reset", window_en, 1'b0);

    // R2 full key, timing of the flag
    send_key(0, 15);
    chk("R2 not unlocked before last byte", unlocked, 1'b0);
    wr(8'hBC, KEYB[16]);
    chk("R2 unlocked after last byte", unlocked, 1'b1);
    chk("R7 window stays off while unmapped", window_en, 1'b0);

    // R5 sticky against further key writes
    wr(8'hBC, 8'h12);
    wr(8'hBC, 8'hFF);
    send_key(0, 5);
    chk("R5 unlocked is sticky", unlocked, 1'b1);

    // R6/R7 map and unmap after unlock
    wr(8'h7F, 8'hB8);
    chk("R7 window on after map", window_en, 1'b1);
    wr(8'h7F, 8'h55);
    chk("R6 other byte on GA port ignored", window_en, 1'b1);
    wr(8'hBC, 8'hA8);
    chk("R6 unmap byte on key port ignored", window_en, 1'b1);
    wr_en = 1'b0; wr_port = 8'h7F; wr_data = 8'hA8;
    @(negedge clk);
    chk("R6 idle strobe ignored", window_en, 1'b1);
    wr(8'h7F, 8'hA8);
    chk("R7 window off after unmap", window_en, 1'b0);
    wr(8'h3C, 8'hB8);
    chk("R6 map byte on other port ignored", window_en, 1'b0);
    wr(8'h7F, 8'hB8);
    chk("R6 remap", window_en, 1'b1);

    // R6/R7 mapping before unlock, R4 interleaved foreign writes
    do_reset();
    chk("R1 window after second reset", window_en, 1'b0);
    wr(8'h7F, 8'hB8);
    chk("R7 mapped but locked gives no window", window_en, 1'b0);
    for (int i = 0; i < 17; i++) begin
      wr(8'hBC, KEYB[i]);
      wr(8'hBD, 8'h00);
      wr(8'h7F, 8'h11);
      wr_en = 1'b0; wr_port = 8'hBC; wr_data = 8'h5A;
      @(negedge clk);
      if (i == 15) chk("R4 no early unlock with interleaving", unlocked, 1'b0);
    end
    chk("R4 foreign writes leave matcher intact", unlocked, 1'b1);
    chk("R7 window on as key completes", window_en, 1'b1);

    // R4 key bytes to a neighbouring port do not count
    do_reset();
    send_key(0, 8);
    for (int i = 9; i < 17; i++) wr(8'hBE, KEYB[i]);
    chk("R4 key bytes on other port ignored", unlocked, 1'b0);

    // R3 restart sweeps
    for (int v = 0; v < 256; v++) sweep_pos(0, 8'(v));
    for (int v = 0; v < 256; v++) sweep_pos(8, 8'(v));
    for (int v = 0; v < 256; v++) sweep_pos(16, 8'(v));
    for (int k = 1; k < 16; k++) begin
      if (k == 8) continue;
      sweep_pos(k, 8'hFF);
      sweep_pos(k, 8'h00);
      sweep_pos(k, KEYB[k] ^ 8'h01);
      sweep_pos(k, 8'hEE);
    end

    // R3 FF at the second position keeps a one-byte head start
    do_reset();
    wr(8'hBC, 8'hFF);
    wr(8'hBC, 8'hFF);
    send_key(1, 16);
    chk("R3 repeated FF then rest of key", unlocked, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule